// File: doc/BRIEF.md
# Guaranteed-Slot Two-Buffer Transmit Scheduler

This block decides when each of two transmit buffers may start sending during the contention-free part of a superframe. Every buffer has an arm bit and a slot number. The superframe timer supplies the current slot number and a one-cycle pulse when a slot begins. An armed buffer does not start until a slot whose number matches its own begins. The block then sends a single-cycle start request to the radio, tagged with the buffer index. It waits for the radio to report completion or error, and then updates the arm bits and the per-buffer status.

Both buffers may be given the same slot. In that case buffer 0 starts first, and each completion hands the next turn to the other buffer. The second buffer in a shared slot starts as soon as the first one completes. A mode input sets what happens after an error. In switch mode both arm bits are dropped and the turn moves to the other buffer. In hold mode both arm bits are kept and nothing more is sent until a later matching slot begins, where the failed buffer goes first.

Top module: `gts_tx_sched`

## Requirements
- R1: While reset is held and directly after it, `tx_start`, `tx_buf`, `busy`, `armed`, `last_ok` and `last_fail` are all 0.
- R2: A high bit of `arm` sets the matching `armed` bit on the next edge, and it wins over a clear in the same cycle. An arm that lands in the same cycle as a slot-start pulse does not count toward that slot start.
- R3: `tx_start` goes high for exactly one cycle, in the cycle after a `slot_start` pulse whose `cur_slot` equals the slot of an armed buffer. `tx_buf` carries that buffer's index, where 0 means buffer 0. No start comes from a non-matching slot.
- R4: While `busy` is high, no new start is issued, and slot-start pulses are ignored.
- R5: If both buffers are armed for the slot that begins, one starts. The other starts in the cycle after the first reports completion, as long as both share the current slot.
- R6: After a completion, the turn passes to the other buffer. When both buffers are next armed for the same slot start, the buffer that did not complete last goes first. After reset, buffer 0 has the turn.
- R7: A completion (`tx_done` while busy) clears the arm bit of the buffer that was sent.
- R8: With `switch_mode` = 1, an error (`tx_err` while busy, without `tx_done`) clears both arm bits. It also gives the turn to the other buffer and issues no further start.
- R9: With `switch_mode` = 0, an error keeps both arm bits and issues no start until the next matching slot start. At that slot start, the failed buffer starts first.
- R10: A completion sets `last_ok` and clears `last_fail` for the sent buffer. An error does the opposite. The other buffer's status stays unchanged.
- R11: If `tx_done` or `tx_err` arrives while `busy` is low, it changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 2 | Per-buffer arm request pulse |
| buf0_slot | input | SLOT_W | Slot assigned to buffer 0 |
| buf1_slot | input | SLOT_W | Slot assigned to buffer 1 |
| cur_slot | input | SLOT_W | Current slot number from the superframe timer |
| slot_start | input | 1 | One-cycle pulse at the start of the current slot |
| switch_mode | input | 1 | 1: on error drop both and switch; 0: hold until next slot |
| tx_done | input | 1 | Radio reports a completed transmission |
| tx_err | input | 1 | Radio reports a failed transmission |
| tx_start | output | 1 | One-cycle transmit start request |
| tx_buf | output | 1 | Buffer index for the start request |
| armed | output | 2 | Current arm bits |
| busy | output | 1 | A transmission is outstanding |
| last_ok | output | 2 | Per buffer: last transmission completed |
| last_fail | output | 2 | Per buffer: last transmission failed |

## Verification
The assertions assume that the radio reports at most one outcome per start, and only after the start cycle. They also assume `tx_done` and `tx_err` are never both high in a cycle where a report is expected. The stimulus meets these conditions by deriving `tx_done` and `tx_err` from the sampled `busy` and `tx_start` outputs. In the random phase it also keeps the slot numbers within a small range so that shared slots, missed slots and slot starts during a busy period all occur. It still applies stray reports while idle and arms on any cycle, because the block must absorb both.

// File: rtl/gts_pkg.sv
package gts_pkg;
  typedef enum logic [1:0] {ST_WAIT = 2'd0, ST_TX = 2'd1, ST_HOLD = 2'd2} gts_state_t;

  // returns {valid, index}: a lone candidate wins, two candidates follow the turn
  function automatic logic [1:0] pick_buf(input logic [1:0] cand, input logic turn);
    logic idx;
    idx = (cand == 2'b11) ? turn : cand[1];
    return {|cand, idx};
  endfunction
endpackage

// File: rtl/gts_trig_bank.sv
module gts_trig_bank #(
  parameter int NB = 2,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set,
  input  logic          clr_one,
  input  logic [IW-1:0] clr_idx,
  input  logic          clr_all,
  output logic [NB-1:0] trig
);
  for (genvar i = 0; i < NB; i++) begin : g_bit
    wire clr_me = clr_all || (clr_one && (clr_idx == IW'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      trig[i] <= 1'b0;
      else if (set[i]) trig[i] <= 1'b1;
      else if (clr_me) trig[i] <= 1'b0;
    end

    // R7
    clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_one && clr_idx == IW'(i) && !set[i]) |=> !trig[i]);
    // R8
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all && !set[i]) |=> !trig[i]);
    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> trig[i]);
  end
endmodule

// File: rtl/gts_status.sv
module gts_status #(
  parameter int NB = 2,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rep_ok,
  input  logic          rep_err,
  input  logic [IW-1:0] rep_idx,
  output logic [NB-1:0] last_ok,
  output logic [NB-1:0] last_fail
);
  for (genvar i = 0; i < NB; i++) begin : g_buf
    wire hit = (rep_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_ok[i]   <= 1'b0;
        last_fail[i] <= 1'b0;
      end else if (hit && rep_ok) begin
        last_ok[i]   <= 1'b1;
        last_fail[i] <= 1'b0;
      end else if (hit && rep_err) begin
        last_ok[i]   <= 1'b0;
        last_fail[i] <= 1'b1;
      end
    end
  end

  // R10
  ok_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_ok |=> (last_ok[$past(rep_idx)] && !last_fail[$past(rep_idx)]));
  // R10
  err_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_err && !rep_ok) |=> (last_fail[$past(rep_idx)] && !last_ok[$past(rep_idx)]));
  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_ok & last_fail) == '0);
endmodule

// File: rtl/gts_tx_sched.sv
module gts_tx_sched #(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        arm,
  input  logic [SLOT_W-1:0] buf0_slot,
  input  logic [SLOT_W-1:0] buf1_slot,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic              slot_start,
  input  logic              switch_mode,
  input  logic              tx_done,
  input  logic              tx_err,
  output logic              tx_start,
  output logic              tx_buf,
  output logic [1:0]        armed,
  output logic              busy,
  output logic [1:0]        last_ok,
  output logic [1:0]        last_fail
);
  import gts_pkg::*;

  gts_state_t state;
  logic cur_buf, turn;
  logic [1:0] cand, pick;
  logic [SLOT_W-1:0] slot_of [2];

  assign slot_of[0] = buf0_slot;
  assign slot_of[1] = buf1_slot;

  for (genvar i = 0; i < 2; i++) begin : g_cand
    assign cand[i] = armed[i] && (slot_of[i] == cur_slot);
  end

  // named events shared by the state logic, trigger bank, status and assertions
  wire done_ev   = (state == ST_TX) && tx_done;
  wire err_ev    = (state == ST_TX) && tx_err && !tx_done;
  wire follow_ev = done_ev && cand[~cur_buf] && (slot_of[~cur_buf] == slot_of[cur_buf]);
  wire slot_ev   = slot_start && (state != ST_TX);
  assign pick    = pick_buf(cand, turn);
  wire start_go  = follow_ev || (slot_ev && pick[1]);
  wire start_idx = follow_ev ? ~cur_buf : pick[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_WAIT;
      cur_buf  <= 1'b0;
      turn     <= 1'b0;
      tx_start <= 1'b0;
      tx_buf   <= 1'b0;
    end else begin
      tx_start <= start_go;
      if (start_go) begin
        tx_buf  <= start_idx;
        cur_buf <= start_idx;
      end
      if (done_ev) turn <= ~cur_buf;
      else if (err_ev) turn <= switch_mode ? ~cur_buf : cur_buf;

      if (start_go)    state <= ST_TX;
      else if (err_ev) state <= switch_mode ? ST_WAIT : ST_HOLD;
      else if (done_ev || slot_ev) state <= ST_WAIT;
    end
  end

  assign busy = (state == ST_TX);

  gts_trig_bank #(.NB(2)) u_trig (
    .clk(clk), .rst_n(rst_n), .set(arm),
    .clr_one(done_ev), .clr_idx(cur_buf),
    .clr_all(err_ev && switch_mode), .trig(armed)
  );

  gts_status #(.NB(2)) u_stat (
    .clk(clk), .rst_n(rst_n), .rep_ok(done_ev), .rep_err(err_ev),
    .rep_idx(cur_buf), .last_ok(last_ok), .last_fail(last_fail)
  );

  // R4
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_done && !tx_err) |=> !tx_start);
  // R3
  start_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> armed[tx_buf]);
  // R3
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> ($past(slot_start) || $past(tx_done)));
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !tx_done) |=> !tx_start);
  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ev && !switch_mode) |=> (!tx_start && !busy));
  // R11
  idle_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !slot_start) |=> (!tx_start && $stable(last_ok) && $stable(last_fail)));
endmodule

// File: tb/gts_tx_sched_test.sv
module gts_tx_sched_test;
  localparam int SW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [1:0] arm;
  logic [SW-1:0] buf0_slot, buf1_slot, cur_slot;
  logic slot_start, switch_mode, tx_done, tx_err;
  logic tx_start, tx_buf, busy;
  logic [1:0] armed, last_ok, last_fail;

  gts_tx_sched #(.SLOT_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .buf0_slot(buf0_slot), .buf1_slot(buf1_slot),
    .cur_slot(cur_slot), .slot_start(slot_start), .switch_mode(switch_mode),
    .tx_done(tx_done), .tx_err(tx_err), .tx_start(tx_start), .tx_buf(tx_buf),
    .armed(armed), .busy(busy), .last_ok(last_ok), .last_fail(last_fail)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: who is armed, whose turn, who is on air
  bit [1:0] m_arm, m_ok, m_fail, c;
  bit m_busy, m_cur, m_turn, m_start, m_buf, dn, er, oth;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_arm = 0; m_ok = 0; m_fail = 0; m_busy = 0; m_cur = 0; m_turn = 0;
      m_start = 0; m_buf = 0;
    end else begin
      c[0] = m_arm[0] && (buf0_slot == cur_slot);
      c[1] = m_arm[1] && (buf1_slot == cur_slot);
      dn = m_busy && tx_done;
      er = m_busy && tx_err && !tx_done;
      oth = !m_cur;
      m_start = 0;
      if (dn) begin
        m_arm[m_cur] = 0; m_ok[m_cur] = 1; m_fail[m_cur] = 0;
        m_turn = oth;
        if (c[oth] && buf0_slot == buf1_slot) begin
          m_start = 1; m_buf = oth; m_cur = oth;
        end else m_busy = 0;
      end else if (er) begin
        m_ok[m_cur] = 0; m_fail[m_cur] = 1; m_busy = 0;
        if (switch_mode) begin m_arm = 0; m_turn = oth; end
        else m_turn = m_cur;
      end else if (slot_start && !m_busy && c != 0) begin
        m_buf = (c == 2'b11) ? m_turn : c[1];
        m_cur = m_buf; m_start = 1; m_busy = 1;
      end
      m_arm = m_arm | arm;
    end
  end

  always @(negedge clk) begin
    if (cmp_on)
      chk({tx_start, tx_buf, armed, busy, last_ok, last_fail} ==
          {m_start, m_buf, m_arm, m_busy, m_ok, m_fail},
          "R3 R7 R10 cycle model",
          int'({tx_start, tx_buf, armed, busy, last_ok, last_fail}),
          int'({m_start, m_buf, m_arm, m_busy, m_ok, m_fail}));
  end

  task automatic tick;
    @(posedge clk); @(negedge clk); #1;
  endtask
  task automatic slot_pulse(input int s);
    cur_slot = SW'(s); slot_start = 1'b1; tick; slot_start = 1'b0;
  endtask
  task automatic done_pulse;
    tx_done = 1'b1; tick; tx_done = 1'b0;
  endtask
  task automatic err_pulse;
    tx_err = 1'b1; tick; tx_err = 1'b0;
  endtask
  task automatic arm_pulse(input bit [1:0] a);
    arm = a; tick; arm = 2'b00;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    finish_run;
  end

  initial begin
    rst_n = 1'b0; arm = 0; buf0_slot = 3; buf1_slot = 5; cur_slot = 0;
    slot_start = 0; switch_mode = 0; tx_done = 0; tx_err = 0;
    repeat (3) @(negedge clk);
    #1;
    chk({tx_start, tx_buf, busy, armed, last_ok, last_fail} == 0, "R1 reset outputs",
        int'({tx_start, tx_buf, busy, armed, last_ok, last_fail}), 0);
    rst_n = 1'b1;
    tick;
    cmp_on = 1'b1;
    chk({tx_start, busy, armed} == 0, "R1 after reset", int'({tx_start, busy, armed}), 0);

    // separate slots, early arming
    arm_pulse(2'b11);
    chk(armed == 2'b11, "R2 arm sets", armed, 3);
    slot_pulse(2);
    chk(tx_start == 0, "R3 no start on foreign slot", tx_start, 0);
    slot_pulse(3);
    chk(tx_start && tx_buf == 0, "R3 start buffer 0 at its slot", int'({tx_start, tx_buf}), 2);
    tick;
    chk(tx_start == 0 && busy, "R3 single pulse", int'({tx_start, busy}), 1);
    slot_pulse(5);
    chk(tx_start == 0, "R4 slot start ignored while busy", tx_start, 0);
    done_pulse;
    chk(armed == 2'b10 && last_ok == 2'b01 && !tx_start, "R7 completion clears sent arm",
        int'({tx_start, armed, last_ok}), int'(5'b0_10_01));
    slot_pulse(5);
    chk(tx_start && tx_buf == 1, "R3 start buffer 1 at its slot", int'({tx_start, tx_buf}), 3);
    tick; done_pulse;
    chk(armed == 0 && last_ok == 2'b11, "R10 both completed", int'({armed, last_ok}), 3);

    // shared slot
    buf0_slot = 4; buf1_slot = 4;
    arm_pulse(2'b11);
    slot_pulse(4);
    chk(tx_start && tx_buf == 0, "R5 buffer 0 first in shared slot", int'({tx_start, tx_buf}), 2);
    tick; done_pulse;
    chk(tx_start && tx_buf == 1, "R5 buffer 1 follows completion", int'({tx_start, tx_buf}), 3);
    tick; done_pulse;
    chk(!tx_start && !busy && armed == 0, "R5 shared slot drained", int'({tx_start, busy, armed}), 0);

    // turn alternation
    arm_pulse(2'b01);
    slot_pulse(4); tick; done_pulse;
    arm_pulse(2'b11);
    slot_pulse(4);
    chk(tx_start && tx_buf == 1, "R6 turn passed to buffer 1", int'({tx_start, tx_buf}), 3);
    tick; done_pulse;
    chk(tx_start && tx_buf == 0, "R6 buffer 0 follows", int'({tx_start, tx_buf}), 2);
    tick; done_pulse;

    // switch-mode error
    switch_mode = 1;
    arm_pulse(2'b11);
    slot_pulse(4);
    chk(tx_start && tx_buf == 1, "R6 buffer 1 turn again", int'({tx_start, tx_buf}), 3);
    tick; err_pulse;
    chk(armed == 0 && !tx_start && !busy, "R8 switch error drops both", int'({armed, tx_start, busy}), 0);
    chk(last_fail == 2'b10 && last_ok == 2'b01, "R10 failure recorded",
        int'({last_fail, last_ok}), int'(4'b10_01));

    // hold-mode error; turn now buffer 0
    switch_mode = 0;
    arm_pulse(2'b11);
    slot_pulse(4);
    chk(tx_start && tx_buf == 0, "R8 turn moved to other buffer", int'({tx_start, tx_buf}), 2);
    tick; err_pulse;
    chk(armed == 2'b11 && !tx_start && !busy, "R9 hold keeps both armed",
        int'({armed, tx_start, busy}), 12);
    tick; tick;
    chk(tx_start == 0, "R9 nothing until next slot", tx_start, 0);
    slot_pulse(4);
    chk(tx_start && tx_buf == 0, "R9 failed buffer first", int'({tx_start, tx_buf}), 2);
    tick; done_pulse;
    chk(tx_start && tx_buf == 1, "R9 other follows", int'({tx_start, tx_buf}), 3);
    tick; done_pulse;

    // stray reports
    tx_done = 1; tick; tx_done = 0;
    tx_err = 1; tick; tx_err = 0;
    chk(last_ok == 2'b11 && last_fail == 0 && !tx_start, "R11 idle report ignored",
        int'({last_ok, last_fail, tx_start}), 24);

    // late arming and set-over-clear
    buf0_slot = 3; buf1_slot = 6;
    arm = 2'b01; slot_pulse(3); arm = 0;
    chk(tx_start == 0 && armed == 2'b01, "R2 arm in slot-start cycle too late",
        int'({tx_start, armed}), 1);
    slot_pulse(3); tick;
    arm = 2'b01; done_pulse; arm = 0;
    chk(armed == 2'b01, "R2 set wins over clear", armed, 1);
    slot_pulse(3); tick; done_pulse;

    // random phase
    for (int k = 0; k < 600; k++) begin
      if (k % 100 == 0) begin
        buf0_slot = SW'(3 + $urandom % 2);
        buf1_slot = SW'(3 + $urandom % 2);
      end
      arm = ($urandom % 6 == 0) ? 2'($urandom) : 2'b00;
      slot_start = ($urandom % 4 == 0);
      cur_slot = SW'(3 + $urandom % 3);
      switch_mode = 1'($urandom);
      tx_done = (busy && !tx_start && $urandom % 3 == 0) || (!busy && $urandom % 9 == 0);
      tx_err = busy && !tx_start && !tx_done && ($urandom % 4 == 0);
      tick;
    end
    arm = 0; slot_start = 0; tx_done = 0; tx_err = 0;
    tick;
    finish_run;
  end
endmodule